// File: doc/BRIEF.md
# Byte-Coherent Free-Running Timer Counter

This block holds a 16-bit up-counter that runs without stopping. A prescaler divides the bus clock by four, so the count advances by one every fourth clock. An 8-bit processor reads the count one byte at a time. It can use either of two address pairs, and each pair has a high-byte location and a low-byte location. Reading a location never changes the count or its pace.

A two-byte read must give a consistent 16-bit value, even though the counter may step between the two accesses. A small sequence state machine keeps this coherence.

The machine has two states:

- `SEQ_IDLE`: no read sequence is pending. A low-byte read returns the live low byte.
- `SEQ_HELD`: a high-byte read has opened a sequence. The low byte from that moment waits in a holding buffer.

It has three transitions:

- **Arm**: `SEQ_IDLE` goes to `SEQ_HELD` on a high-byte read, which also captures the live low byte.
- **Re-read**: `SEQ_HELD` stays in `SEQ_HELD` on a high-byte read. The buffer is not reloaded.
- **Release**: `SEQ_HELD` goes to `SEQ_IDLE` on a low-byte read, which returns the buffered byte.

Both address pairs share the one machine and the one buffer. The running count also leaves the block on a debug output.

Top module: `frc_timer_top`

## Requirements
- R1: The count starts at zero, steps by exactly one (modulo 65536) on every fourth clock edge, and makes its first step on the fourth rising edge after reset is released.
- R2: While reset is asserted, the count, the read data and the pending sequence are all cleared. A low-byte read right after reset returns the live low byte, even if a sequence was pending before the reset.
- R3: Read strobes at any address and at any rate leave the count's progression unchanged: 40 clocks always add exactly 10.
- R4: The address map is fixed: 0 is the primary high byte, 1 the primary low byte, 2 the alternate high byte and 3 the alternate low byte. The high byte is count bits 15:8 and the low byte is bits 7:0.
- R5: A low-byte read in `SEQ_IDLE` returns the count's low byte as it is at the strobe edge.
- R6: A high-byte read returns the count's high byte at the strobe edge. In `SEQ_IDLE` it also captures the live low byte and moves to `SEQ_HELD`.
- R7: Further high-byte reads in `SEQ_HELD` do not reload the buffer, which keeps the value from the first high-byte read.
- R8: A low-byte read in `SEQ_HELD` returns the buffered byte and moves to `SEQ_IDLE`, so the next low-byte read returns live data again.
- R9: One sequence state and one buffer serve both pairs. A high-byte read at one pair followed by a low-byte read at the other pair completes the same sequence.
- R10: The read data updates one clock after the strobe edge and holds its value while no strobe is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_stb | input | 1 | One-cycle read strobe |
| rd_addr | input | 2 | Byte location selected by the read |
| rd_data | output | 8 | Registered read data |
| dbg_count | output | 16 | Live counter value, for observation |

## Verification
The assertions assume that each access is a single-cycle `rd_stb` pulse and that `rd_addr` is valid in the same cycle. They also assume that reads happen only while reset is deasserted. The bench drives every strobe and address on the falling edge and drops the strobe after one cycle. It spaces buffered reads at least five clocks apart, so the live and held low bytes always differ at the moment they are compared. It records the debug count on the falling edge before each strobe, which is exactly the value the design samples on the next rising edge.

// File: rtl/frc_pkg.sv
package frc_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_HELD = 1'b1
    } seq_state_e;

    localparam int unsigned LOC_PRI_HI = 0;
    localparam int unsigned LOC_PRI_LO = 1;
    localparam int unsigned LOC_ALT_HI = 2;
    localparam int unsigned LOC_ALT_LO = 3;

endpackage

// File: rtl/frc_prescaler.sv
module frc_prescaler #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PW'(1);
        end
    end

    assign tick = (phase_q == LAST);

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R1

endmodule

// File: rtl/frc_counter.sv
module frc_counter #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    output logic [CW-1:0] count
);
    logic [CW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= count_q + CW'(1);
        end
    end

    assign count = count_q;

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> count_q == $past(count_q) + CW'(1)); // R1
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count_q)); // R3

endmodule

// File: rtl/frc_lsb_hold.sv
module frc_lsb_hold
    import frc_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic              is_hi,
    input  logic [BYTE_W-1:0] live_lo,
    output logic [BYTE_W-1:0] held_lo,
    output logic              pending
);
    seq_state_e        state_q, state_d;
    logic              capture;
    logic [BYTE_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (rd_stb && is_hi) begin
                    state_d = SEQ_HELD;
                    capture = 1'b1;
                end
            end
            SEQ_HELD: begin
                if (rd_stb && !is_hi) begin
                    state_d = SEQ_IDLE;
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (capture) begin
            hold_q <= live_lo;
        end
    end

    assign held_lo = hold_q;
    assign pending = (state_q == SEQ_HELD);

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == SEQ_HELD |=> $stable(hold_q)); // R7
    AST_HI_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && is_hi |=> state_q == SEQ_HELD); // R6
    AST_LO_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == SEQ_HELD && rd_stb && !is_hi |=> state_q == SEQ_IDLE); // R8

endmodule

// File: rtl/frc_timer_top.sv
module frc_timer_top
    import frc_pkg::*;
#(
    parameter int unsigned BYTE_W       = 8,
    parameter int unsigned PRESCALE_DIV = 4,
    parameter int unsigned ADDR_W       = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_stb,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [BYTE_W-1:0]   rd_data,
    output logic [2*BYTE_W-1:0] dbg_count
);
    localparam int unsigned CNT_W = 2 * BYTE_W;

    logic              tick;
    logic [CNT_W-1:0]  count;
    logic [BYTE_W-1:0] held_lo;
    logic              pending;
    logic              is_hi;
    logic [BYTE_W-1:0] rd_q;

    assign is_hi = (rd_addr == ADDR_W'(LOC_PRI_HI)) || (rd_addr == ADDR_W'(LOC_ALT_HI));

    frc_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    frc_counter #(.CW(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .count (count)
    );

    frc_lsb_hold #(.BYTE_W(BYTE_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_stb  (rd_stb),
        .is_hi   (is_hi),
        .live_lo (count[BYTE_W-1:0]),
        .held_lo (held_lo),
        .pending (pending)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_stb) begin
            if (is_hi) begin
                rd_q <= count[CNT_W-1:BYTE_W];
            end else if (pending) begin
                rd_q <= held_lo;
            end else begin
                rd_q <= count[BYTE_W-1:0];
            end
        end
    end

    assign rd_data   = rd_q;
    assign dbg_count = count;

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_q)); // R10
    AST_HI_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && is_hi |=> rd_q == $past(count[CNT_W-1:BYTE_W])); // R6
    AST_LO_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && !is_hi && !pending |=> rd_q == $past(count[BYTE_W-1:0])); // R5

endmodule

// File: tb/frc_timer_top_tb.sv
`timescale 1ns/1ps
module frc_timer_top_tb_top;

    typedef struct packed {
        logic [1:0] addr;
        logic [1:0] src;   // 0 live high, 1 live low, 2 buffered low
        logic       cap;   // this high read opens a sequence
        logic [3:0] gap;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 2'd1, 1'b0, 4'd5},  // R5 live low, primary
        '{2'd3, 2'd1, 1'b0, 4'd6},  // R5 live low, alternate
        '{2'd0, 2'd0, 1'b1, 4'd5},  // R6 arm
        '{2'd0, 2'd0, 1'b0, 4'd6},  // R7 re-read
        '{2'd2, 2'd0, 1'b0, 4'd7},  // R7 re-read alt
        '{2'd1, 2'd2, 1'b0, 4'd5},  // R8 buffered
        '{2'd1, 2'd1, 1'b0, 4'd6},  // R8 released
        '{2'd2, 2'd0, 1'b1, 4'd5},  // R9 arm alt
        '{2'd1, 2'd2, 1'b0, 4'd6},  // R9 release primary
        '{2'd3, 2'd1, 1'b0, 4'd5},  // R5 live
        '{2'd2, 2'd0, 1'b1, 4'd9},  // R4 alt arm
        '{2'd3, 2'd2, 1'b0, 4'd6}   // R4 alt release
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_stb = 1'b0;
    logic [1:0]  rd_addr = 2'd0;
    logic [7:0]  rd_data;
    logic [15:0] dbg_count;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    frc_timer_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_stb    (rd_stb),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .dbg_count (dbg_count)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // one read at the next falling edge; returns the count seen at the strobe edge
    task automatic do_read(input logic [1:0] a, output logic [15:0] snap);
        snap = dbg_count;
        rd_addr = a;
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    initial begin
        logic [15:0] snap;
        logic [15:0] start;
        logic [7:0]  bench_buf;
        logic [7:0]  expv;
        logic [7:0]  keep;
        bench_buf = 8'h00;

        repeat (5) @(negedge clk);
        check("R2 count in reset", dbg_count, 16'h0000);
        check("R2 rd_data in reset", {8'h00, rd_data}, 16'h0000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 no step before fourth edge", dbg_count, 16'h0000);
        @(negedge clk);
        check("R1 first step on fourth edge", dbg_count, 16'h0001);

        start = dbg_count;
        repeat (40) @(negedge clk);
        check("R1 ten steps in 40 clocks", dbg_count, start + 16'd10);

        for (int i = 0; i < NV; i++) begin
            repeat (int'(VECS[i].gap)) @(negedge clk);
            do_read(VECS[i].addr, snap);
            case (VECS[i].src)
                2'd0:    expv = snap[15:8];
                2'd1:    expv = snap[7:0];
                default: expv = bench_buf;
            endcase
            if (VECS[i].cap) bench_buf = snap[7:0];
            check($sformatf("R4 R5 R6 R7 R8 R9 vector %0d", i), {8'h00, rd_data}, {8'h00, expv});
        end

        // R3: strobe every cycle at all addresses
        start = dbg_count;
        for (int k = 0; k < 40; k++) begin
            do_read(2'(k % 4), snap);
        end
        check("R3 reads keep pace", dbg_count, start + 16'd10);

        // R10: data holds without strobe
        repeat (5) @(negedge clk);
        do_read(2'd1, snap);
        keep = rd_data;
        check("R10 updated after strobe", {8'h00, keep}, {8'h00, snap[7:0]});
        repeat (12) @(negedge clk);
        check("R10 holds while idle", {8'h00, rd_data}, {8'h00, keep});

        // R2: reset clears a pending sequence
        repeat (7) @(negedge clk);
        do_read(2'd0, snap);
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 count cleared", dbg_count, 16'h0000);
        rst_n = 1'b1;
        repeat (9) @(negedge clk);
        do_read(2'd1, snap);
        check("R2 live low after reset", {8'h00, rd_data}, {8'h00, snap[7:0]});

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule